// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

A target device that stays powered through a system reset can still be partway through a transfer. It may hold SDA low, or it may be waiting for clocks to shift out the rest of a byte. This block frees such a bus before the normal I2C controller takes over. A one-cycle start strobe launches the sequence. The block then drives SCL and SDA open-drain: it can only pull a line low or release it. It reads the lines back through a two-flop synchronizer and steps through a fixed recovery order. At the end it leaves both lines released and pulses done.

The order is as follows. After a settling phase with both lines released, the block issues a pseudo-stop if both lines read high. A pseudo-stop pulls SDA low for one half-period and then releases it for one half-period. If the lines do not both read high, the block gives one extra SCL pulse and checks again. If both lines now read high, it issues the pseudo-stop at that point. Next come nine SCL pulses, whatever level the lines show. Last, the block tries a final pseudo-stop, again only if both lines read high. A status output reports whether that final pseudo-stop was issued, which tells the host whether the bus was left idle. Every low and high phase lasts `HALF_CYC` system clocks; the default is 250, which is 5 us at 50 MHz and gives about 100 kHz.

Top module: `i2c_bus_unjam`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `scl_pull_o`, `sda_pull_o`, `busy_o` and `done_o` are all 0.
- R2: Every low pulse on `scl_pull_o` or `sda_pull_o` lasts exactly `HALF_CYC` clock cycles.
- R3: After a settling phase of `HALF_CYC` cycles with both lines released, a pseudo-stop is issued if both lines read high. A pseudo-stop is `sda_pull_o`=1 for `HALF_CYC` cycles, then released for `HALF_CYC` cycles. `sda_pull_o` is never 1 while `scl_pull_o` is 1.
- R4: If the first check fails, one extra SCL pulse is given (pulled for `HALF_CYC` cycles, released for `HALF_CYC` cycles). A pseudo-stop follows only if both lines then read high.
- R5: After the steps of R3 and R4, exactly nine SCL pulses are always issued, so a run contains 9 SCL pulses (first pseudo-stop succeeded) or 10 (it failed).
- R6: After the nine pulses, a final pseudo-stop is issued only if both lines read high. `last_stop_o` is 1 exactly when that final pseudo-stop was issued. It is cleared when a run starts and holds its value after done.
- R7: `busy_o` rises the cycle after an accepted start and stays high through the done cycle. `done_o` is a single-cycle pulse with both pull outputs at 0. The run lasts (number of phases × `HALF_CYC`) + 1 busy cycles.
- R8: A start strobe that arrives while `busy_o` is 1 is ignored and does not change the sequence or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin recovery |
| scl_in_i | input | 1 | SCL line level (asynchronous) |
| sda_in_i | input | 1 | SDA line level (asynchronous) |
| scl_pull_o | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| last_stop_o | output | 1 | Final pseudo-stop was issued in the last run |

## Verification
Most wrong internal states show up at the pull outputs within one half-period. A wrong step decision moves an SDA pulse or adds or drops an SCL pulse. A miscounted clock loop changes the run length by a multiple of `2*HALF_CYC` and changes the SCL pulse count. A wrong timer changes a pulse width at its first falling edge. The status flag and the done pulse can only be checked once the run ends. The bench models a device that releases SDA after a chosen number of SCL rising edges, and sweeps that number through every step of the order. This shows that each check reads the line at the right point.

// File: rtl/unjam_pkg.sv
package unjam_pkg;

    localparam int unsigned DEF_NUM_CLOCKS = 9;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_XC_LO,
        ST_XC_HI,
        ST_PS_LO,
        ST_PS_HI,
        ST_CK_LO,
        ST_CK_HI,
        ST_DONE
    } step_e;

    typedef enum logic [1:0] {
        PS_FIRST,
        PS_RETRY,
        PS_FINAL
    } ps_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } drive_t;

    function automatic drive_t drive_of(step_e s);
        drive_t d;
        d.scl = (s == ST_XC_LO) || (s == ST_CK_LO);
        d.sda = (s == ST_PS_LO);
        return d;
    endfunction

    function automatic logic is_timed(step_e s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) chain_q[i] <= '1;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/unjam_timer.sv
module unjam_timer #(
    parameter int unsigned HALF_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i)       cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);

    p_phase_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!run_i) |=> (cnt_q == '0));
    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/unjam_fsm.sv
module unjam_fsm
    import unjam_pkg::*;
#(
    parameter int unsigned NUM_CLOCKS = DEF_NUM_CLOCKS
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic tick_i,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic timed_o,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o,
    output logic last_stop_o
);
    localparam int unsigned NW = $clog2(NUM_CLOCKS + 1);
    localparam logic [NW-1:0] NLAST = NW'(NUM_CLOCKS - 1);

    step_e     state_q, state_d;
    ps_kind_e  kind_q, kind_d;
    logic [NW-1:0] nclk_q, nclk_d;
    logic      stat_q, stat_d;
    drive_t    drv_q;
    logic      both_hi;

    assign both_hi = scl_s_i && sda_s_i;

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        nclk_d  = nclk_q;
        stat_d  = stat_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_SETTLE;
                stat_d  = 1'b0;
                nclk_d  = '0;
            end
            ST_SETTLE: if (tick_i) begin
                kind_d  = PS_FIRST;
                state_d = both_hi ? ST_PS_LO : ST_XC_LO;
            end
            ST_XC_LO: if (tick_i) state_d = ST_XC_HI;
            ST_XC_HI: if (tick_i) begin
                kind_d  = PS_RETRY;
                state_d = both_hi ? ST_PS_LO : ST_CK_LO;
            end
            ST_PS_LO: if (tick_i) state_d = ST_PS_HI;
            ST_PS_HI: if (tick_i) begin
                if (kind_q == PS_FINAL) begin
                    stat_d  = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_CK_LO;
                end
            end
            ST_CK_LO: if (tick_i) state_d = ST_CK_HI;
            ST_CK_HI: if (tick_i) begin
                if (nclk_q == NLAST) begin
                    kind_d  = PS_FINAL;
                    state_d = both_hi ? ST_PS_LO : ST_DONE;
                end else begin
                    nclk_d  = nclk_q + 1'b1;
                    state_d = ST_CK_LO;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            kind_q  <= PS_FIRST;
            nclk_q  <= '0;
            stat_q  <= 1'b0;
            drv_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            nclk_q  <= nclk_d;
            stat_q  <= stat_d;
            drv_q   <= drive_of(state_d);
        end
    end

    assign timed_o     = is_timed(state_q);
    assign scl_pull_o  = drv_q.scl;
    assign sda_pull_o  = drv_q.sda;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign last_stop_o = stat_q;

    p_reset_release_r1: assert property (@(posedge clk)
        rst |=> (!scl_pull_o && !sda_pull_o && !busy_o));
    p_no_dual_pull_r3: assert property (@(posedge clk) disable iff (rst)
        sda_pull_o |-> !scl_pull_o);
    p_clock_bound_r5: assert property (@(posedge clk) disable iff (rst)
        nclk_q < NW'(NUM_CLOCKS));
    p_status_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && !last_stop_o));
    p_done_released_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!scl_pull_o && !sda_pull_o));
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
    parameter int unsigned HALF_CYC    = 250,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned NUM_CLOCKS  = unjam_pkg::DEF_NUM_CLOCKS
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic scl_in_i,
    input  logic sda_in_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o,
    output logic last_stop_o
);
    logic [1:0] lines_s;
    logic       tick;
    logic       timed;

    unjam_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_in_i, sda_in_i}),
        .q_o (lines_s)
    );

    unjam_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (timed),
        .tick_o (tick)
    );

    unjam_fsm #(.NUM_CLOCKS(NUM_CLOCKS)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .tick_i      (tick),
        .scl_s_i     (lines_s[1]),
        .sda_s_i     (lines_s[0]),
        .timed_o     (timed),
        .scl_pull_o  (scl_pull_o),
        .sda_pull_o  (sda_pull_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .last_stop_o (last_stop_o)
    );
endmodule

// File: tb/i2c_bus_unjam_tb_top.sv
module i2c_bus_unjam_tb_top;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic scl_pull, sda_pull, busy, done, last_stop;
    logic scl_line, sda_line;

    int k_sda = 0;
    logic hold_scl = 1'b0;
    int fall_cnt = 0;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    int scl_pulses = 0, sda_pulses = 0, width_err = 0, dual = 0;
    int busy_cnt = 0, done_cnt = 0, done_err = 0;
    int scl_w = 0, sda_w = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = !scl_pull && !hold_scl;
    assign sda_line = !sda_pull && !(fall_cnt < k_sda);

    i2c_bus_unjam #(.HALF_CYC(H)) dut_i (
        .clk (clk), .rst (rst), .start_i (start),
        .scl_in_i (scl_line), .sda_in_i (sda_line),
        .scl_pull_o (scl_pull), .sda_pull_o (sda_pull),
        .busy_o (busy), .done_o (done), .last_stop_o (last_stop)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (scl_pull) scl_w++;
            else if (prev_scl) begin
                if (scl_w != H) width_err++;
                scl_w = 0;
                fall_cnt++;
            end
            if (sda_pull) sda_w++;
            else if (prev_sda) begin
                if (sda_w != H) width_err++;
                sda_w = 0;
            end
            if (scl_pull && !prev_scl) scl_pulses++;
            if (sda_pull && !prev_sda) sda_pulses++;
            if (scl_pull && sda_pull) dual++;
            if (busy) busy_cnt++;
            if (done) begin
                done_cnt++;
                if (scl_pull || sda_pull) done_err++;
            end
            prev_scl = scl_pull;
            prev_sda = sda_pull;
        end
    end

    // One run; the phase counts come from R3..R6: settle 1, extra clock 2,
    // each pseudo-stop 2, nine clocks 18.
    task automatic run_case(input string name, input int ks, input logic hs,
                            input int e_sda, input int e_scl, input int e_phases,
                            input int e_stat, input logic extra_start);
        int b0, s0, d0, w0, dn0, de0, c0, waited;
        @(negedge clk); #1;
        k_sda = ks; hold_scl = hs; fall_cnt = 0;
        b0 = busy_cnt; s0 = scl_pulses; d0 = sda_pulses; w0 = width_err;
        dn0 = done_cnt; de0 = done_err; c0 = dual;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        check({"R7 busy after start ", name}, int'(busy), 1);
        waited = 0;
        while (done_cnt == dn0 && waited < 2000) begin
            @(negedge clk); #1;
            waited++;
            if (extra_start && waited == 10) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check({"R3/R4/R6 sda pulses ", name}, sda_pulses - d0, e_sda);
        check({"R5 scl pulses ", name}, scl_pulses - s0, e_scl);
        check({"R7 busy length ", name}, busy_cnt - b0, e_phases * H + 1);
        check({"R6 last_stop ", name}, int'(last_stop), e_stat);
        check({"R2 pulse width ", name}, width_err - w0, 0);
        check({"R3 no dual pull ", name}, dual - c0, 0);
        check({"R7 single done ", name}, done_cnt - dn0, 1);
        check({"R7 released at done ", name}, done_err - de0, 0);
        check({"R7 idle after ", name}, int'(busy), 0);
        if (extra_start) check({"R8 restart ignored ", name}, busy_cnt - b0, e_phases * H + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 scl_pull in reset", int'(scl_pull), 0);
        check("R1 sda_pull in reset", int'(sda_pull), 0);
        check("R1 busy in reset", int'(busy), 0);
        @(negedge clk); #1;
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1 done after reset", int'(done), 0);
        check("R1 busy after reset", int'(busy), 0);

        run_case("free bus", 0, 1'b0, 2, 9, 23, 1, 1'b0);
        run_case("free bus restart", 0, 1'b0, 2, 9, 23, 1, 1'b1);
        run_case("scl stuck", 0, 1'b1, 0, 10, 21, 0, 1'b0);
        // device holds SDA low until k SCL rising edges have passed
        for (int k = 1; k <= 11; k++) begin
            string nm;
            int es, et, ep;
            nm = $sformatf("sda k=%0d", k);
            if (k == 1)       begin es = 2; ep = 25; et = 1; end
            else if (k <= 10) begin es = 1; ep = 23; et = 1; end
            else              begin es = 0; ep = 21; et = 0; end
            run_case(nm, k, 1'b0, es, 10, ep, et, 1'b0);
        end
        // status holds while idle
        repeat (5) @(negedge clk);
        #1;
        check("R6 last_stop held", int'(last_stop), 0);
        finish_run();
    end
endmodule